// File: doc/BRIEF.md
# Transmit Frame Sequencer with Delimiter Flag

The block builds one outgoing frame for a low-rate wireless link each time it is told to start. After a start strobe it waits a fixed number of symbol periods. It then sends a run of zero preamble bytes and a delimiter byte that it generates itself. Next it streams a length byte and the body bytes that the length announces, reading them from a byte-wide, show-ahead transmit FIFO. It ends the frame with a 16-bit frame check sequence that it computes over the body. Every byte leaves as two 4-bit symbols, one symbol for each pulse of a symbol-rate enable.

A status output, the delimiter flag, is high from the moment the delimiter has been completely sent until the frame is over. A timer can capture its edges to timestamp the frame. If the FIFO runs dry while a byte is still owed, the frame is cut short, the flag drops and a sticky underflow indication is raised. The indication stays set until a clear input resets it.

Top module: `tfr_tx_framer`

## Requirements
- R1: After reset `sym_valid_o`, `sfd_o`, `underflow_o` and `fifo_rd_o` are all 0.
- R2: A start strobe accepted while idle is followed by 12 symbol ticks without output, and the first symbol is emitted on the 13th tick after the strobe.
- R3: A frame opens with 8 symbols of value 0 (4 zero bytes), followed by the delimiter 0xA7 sent as symbol 0x7 and then symbol 0xA. Each byte is sent as its low nibble first, then its high nibble.
- R4: The first FIFO byte is sent unchanged as the length byte. Its bits [6:0] give a length L, and bit 7 is ignored. The block then reads and sends L-2 further body bytes, or none when L is 0 or 1.
- R5: The check sequence uses polynomial x^16+x^12+x^5+1 with initial value 0. Each body byte is fed in least significant bit first, so the register shifts right with a feedback mask of 0x8408. Only the body bytes are covered, not the length byte. The result is sent low byte first, each byte low nibble first.
- R6: `sfd_o` rises on the tick that emits the first length symbol and falls on the first tick after the last check-sequence symbol. It is 1 while each length, body and check symbol is presented.
- R7: `fifo_rd_o` is high for one cycle only, on a symbol tick at which a FIFO byte is needed and the FIFO is not empty. One pulse is made per length or body byte.
- R8: If the FIFO is empty on a tick at which a byte is needed, no symbol is emitted, `sfd_o` goes to 0, `underflow_o` goes to 1, the block returns to idle and it makes no further reads.
- R9: `underflow_o` stays 1 until `clr_i` is high. A new underflow in the same cycle wins over the clear.
- R10: A start strobe received while a frame is pending or in progress has no effect on the symbols sent or the FIFO reads.
- R11: `sym_valid_o` is high for exactly the cycle after each emitting tick, and `sym_o` holds the emitted symbol in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, one cycle |
| clr_i | input | 1 | Clears the sticky underflow flag |
| sym_tick_i | input | 1 | One-cycle pulse per symbol period |
| fifo_data_i | input | 8 | Head byte of the transmit FIFO (show-ahead) |
| fifo_empty_i | input | 1 | Transmit FIFO is empty |
| fifo_rd_o | output | 1 | Pops the FIFO head byte |
| sym_o | output | 4 | Current 4-bit symbol |
| sym_valid_o | output | 1 | A new symbol was emitted on the last tick |
| sfd_o | output | 1 | Delimiter sent, frame still in progress |
| underflow_o | output | 1 | Sticky FIFO underflow indication |

## Verification
A wrong sequencer state or count changes the number of symbols or FIFO pops in the frame, and that becomes visible within one symbol tick. A shifted delay count moves the first symbol by whole ticks. A corrupted check register stays hidden until the last four symbols of the frame, so every frame is compared symbol by symbol, and the flag's high time is compared against the expected number of ticks. Underflow frames show whether the sequencer stops at the exact byte where the FIFO ran dry. Frames with no body bytes and frames with bit 7 set in the length byte exercise the length decode.

// File: rtl/tfr_pkg.sv
package tfr_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WAIT,
      ST_PRE,
      ST_DELIM,
      ST_LEN,
      ST_BODY,
      ST_FCS_LO,
      ST_FCS_HI,
      ST_TAIL
   } tfr_state_t;

   function automatic logic [15:0] tfr_rev16(input logic [15:0] v);
      logic [15:0] r;
      for (int i = 0; i < 16; i++) r[i] = v[15-i];
      return r;
   endfunction

endpackage

// File: rtl/tfr_crc16.sv
module tfr_crc16 #(
   parameter logic [15:0] POLY      = 16'h1021,
   parameter logic [15:0] INIT      = 16'h0000,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init_i,
   input  logic        en_i,
   input  logic [7:0]  byte_i,
   output logic [15:0] crc_o
);
   import tfr_pkg::*;

   localparam logic [15:0] POLY_REV = tfr_rev16(POLY);

   logic [15:0] crc_q;
   logic [15:0] crc_nxt;

   generate
      if (LSB_FIRST) begin : g_lsb
         always_comb begin
            logic [15:0] c;
            logic        fb;
            c = crc_q;
            for (int i = 0; i < 8; i++) begin
               fb = c[0] ^ byte_i[i];
               c  = c >> 1;
               if (fb) c = c ^ POLY_REV;
            end
            crc_nxt = c;
         end
      end else begin : g_msb
         always_comb begin
            logic [15:0] c;
            logic        fb;
            c = crc_q;
            for (int i = 7; i >= 0; i--) begin
               fb = c[15] ^ byte_i[i];
               c  = c << 1;
               if (fb) c = c ^ POLY;
            end
            crc_nxt = c;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      crc_q <= INIT;
      else if (init_i) crc_q <= INIT;
      else if (en_i)   crc_q <= crc_nxt;
   end

   assign crc_o = crc_q;

endmodule

// File: rtl/tfr_nib_ser.sv
module tfr_nib_ser #(
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load_i,
   input  logic       next_i,
   input  logic [7:0] byte_i,
   output logic [3:0] sym_o,
   output logic       valid_o
);
   logic [3:0] first_nib;
   logic [3:0] second_nib;
   logic [3:0] held_q;

   generate
      if (LOW_FIRST) begin : g_low
         assign first_nib  = byte_i[3:0];
         assign second_nib = byte_i[7:4];
      end else begin : g_high
         assign first_nib  = byte_i[7:4];
         assign second_nib = byte_i[3:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sym_o   <= '0;
         held_q  <= '0;
         valid_o <= 1'b0;
      end else if (load_i) begin
         sym_o   <= first_nib;
         held_q  <= second_nib;
         valid_o <= 1'b1;
      end else if (next_i) begin
         sym_o   <= held_q;
         valid_o <= 1'b1;
      end else begin
         valid_o <= 1'b0;
      end
   end

endmodule

// File: rtl/tfr_tx_framer.sv
module tfr_tx_framer #(
   parameter int          START_DELAY   = 12,
   parameter int          PRE_BYTES     = 4,
   parameter logic [7:0]  DELIM_BYTE    = 8'hA7,
   parameter int          LEN_BITS      = 7,
   parameter logic [15:0] CRC_POLY      = 16'h1021,
   parameter logic [15:0] CRC_INIT      = 16'h0000,
   parameter bit          CRC_LSB_FIRST = 1'b1,
   parameter bit          NIB_LOW_FIRST = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       clr_i,
   input  logic       sym_tick_i,
   input  logic [7:0] fifo_data_i,
   input  logic       fifo_empty_i,
   output logic       fifo_rd_o,
   output logic [3:0] sym_o,
   output logic       sym_valid_o,
   output logic       sfd_o,
   output logic       underflow_o
);
   import tfr_pkg::*;

   localparam int FCS_BYTES = 2;
   localparam int M1        = (START_DELAY > PRE_BYTES) ? START_DELAY : PRE_BYTES;
   localparam int M2        = (M1 > (1 << LEN_BITS)) ? M1 : (1 << LEN_BITS);
   localparam int CNT_W     = $clog2(M2 + 1);

   generate
      if (START_DELAY < 1) begin : g_bad_delay
         $error("START_DELAY must be at least 1");
      end
      if (PRE_BYTES < 1) begin : g_bad_pre
         $error("PRE_BYTES must be at least 1");
      end
      if (LEN_BITS < 2 || LEN_BITS > 8) begin : g_bad_len
         $error("LEN_BITS must lie in 2..8");
      end
   endgenerate

   tfr_state_t         state_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               half_q;
   logic               sfd_q;
   logic               unf_q;

   logic               in_frame;
   logic               fetch_st;
   logic               need_byte;
   logic               starve;
   logic               ld_byte;
   logic               nx_nib;
   logic               start_ok;
   logic [7:0]         tx_byte;
   logic [15:0]        crc_val;
   logic [LEN_BITS-1:0] len_field;
   logic [CNT_W-1:0]   body_cnt;

   always_comb begin
      in_frame  = (state_q == ST_PRE)    || (state_q == ST_DELIM) ||
                  (state_q == ST_LEN)    || (state_q == ST_BODY)  ||
                  (state_q == ST_FCS_LO) || (state_q == ST_FCS_HI);
      fetch_st  = (state_q == ST_LEN) || (state_q == ST_BODY);
      need_byte = sym_tick_i && !half_q && fetch_st;
      starve    = need_byte && fifo_empty_i;
      fifo_rd_o = need_byte && !fifo_empty_i;
      ld_byte   = sym_tick_i && in_frame && !half_q && !starve;
      nx_nib    = sym_tick_i && in_frame && half_q;
      start_ok  = start_i && (state_q == ST_IDLE);
      len_field = fifo_data_i[LEN_BITS-1:0];
      if (len_field < LEN_BITS'(FCS_BYTES)) body_cnt = '0;
      else body_cnt = CNT_W'(len_field) - CNT_W'(FCS_BYTES);
      case (state_q)
         ST_DELIM:  tx_byte = DELIM_BYTE;
         ST_LEN,
         ST_BODY:   tx_byte = fifo_data_i;
         ST_FCS_LO: tx_byte = crc_val[7:0];
         ST_FCS_HI: tx_byte = crc_val[15:8];
         default:   tx_byte = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         half_q  <= 1'b0;
         sfd_q   <= 1'b0;
         unf_q   <= 1'b0;
      end else begin
         if (starve)     unf_q <= 1'b1;
         else if (clr_i) unf_q <= 1'b0;

         case (state_q)
            ST_IDLE: begin
               if (start_ok) begin
                  state_q <= ST_WAIT;
                  cnt_q   <= CNT_W'(START_DELAY);
                  half_q  <= 1'b0;
               end
            end
            ST_WAIT: begin
               if (sym_tick_i) begin
                  if (cnt_q == CNT_W'(1)) begin
                     state_q <= ST_PRE;
                     cnt_q   <= CNT_W'(PRE_BYTES);
                  end else begin
                     cnt_q <= cnt_q - CNT_W'(1);
                  end
               end
            end
            ST_TAIL: begin
               if (sym_tick_i) begin
                  sfd_q   <= 1'b0;
                  state_q <= ST_IDLE;
               end
            end
            default: begin
               if (sym_tick_i && !half_q) begin
                  if (starve) begin
                     state_q <= ST_IDLE;
                     sfd_q   <= 1'b0;
                  end else begin
                     half_q <= 1'b1;
                     if (state_q == ST_LEN) begin
                        cnt_q <= body_cnt;
                        sfd_q <= 1'b1;
                     end
                  end
               end else if (sym_tick_i) begin
                  half_q <= 1'b0;
                  case (state_q)
                     ST_PRE: begin
                        if (cnt_q == CNT_W'(1)) state_q <= ST_DELIM;
                        else cnt_q <= cnt_q - CNT_W'(1);
                     end
                     ST_DELIM: state_q <= ST_LEN;
                     ST_LEN: begin
                        if (cnt_q == '0) state_q <= ST_FCS_LO;
                        else state_q <= ST_BODY;
                     end
                     ST_BODY: begin
                        if (cnt_q == CNT_W'(1)) state_q <= ST_FCS_LO;
                        else cnt_q <= cnt_q - CNT_W'(1);
                     end
                     ST_FCS_LO: state_q <= ST_FCS_HI;
                     ST_FCS_HI: state_q <= ST_TAIL;
                     default:   state_q <= ST_IDLE;
                  endcase
               end
            end
         endcase
      end
   end

   tfr_crc16 #(
      .POLY      (CRC_POLY),
      .INIT      (CRC_INIT),
      .LSB_FIRST (CRC_LSB_FIRST)
   ) u_crc (
      .clk    (clk),
      .rst_n  (rst_n),
      .init_i (start_ok),
      .en_i   (fifo_rd_o && (state_q == ST_BODY)),
      .byte_i (fifo_data_i),
      .crc_o  (crc_val)
   );

   tfr_nib_ser #(
      .LOW_FIRST (NIB_LOW_FIRST)
   ) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (ld_byte),
      .next_i  (nx_nib),
      .byte_i  (tx_byte),
      .sym_o   (sym_o),
      .valid_o (sym_valid_o)
   );

   assign sfd_o       = sfd_q;
   assign underflow_o = unf_q;

endmodule

// File: rtl/tfr_chk.sv
module tfr_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic clr_i,
   input logic sym_tick_i,
   input logic fifo_empty_i,
   input logic fifo_rd_o,
   input logic sym_valid_o,
   input logic sfd_o,
   input logic underflow_o
);

   AST_READ_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd_o |-> !fifo_empty_i); // R7

   AST_READ_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd_o |-> sym_tick_i); // R7

   AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      sym_valid_o |-> $past(sym_tick_i)); // R11

   AST_SFD_FALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sfd_o) |-> !sym_valid_o); // R6

   AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (underflow_o && !clr_i) |=> underflow_o); // R9

   AST_UNDERFLOW_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(underflow_o) |-> (!sfd_o && !sym_valid_o)); // R8

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!sym_valid_o && !sfd_o && !underflow_o)); // R1

endmodule

bind tfr_tx_framer tfr_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .clr_i        (clr_i),
   .sym_tick_i   (sym_tick_i),
   .fifo_empty_i (fifo_empty_i),
   .fifo_rd_o    (fifo_rd_o),
   .sym_valid_o  (sym_valid_o),
   .sfd_o        (sfd_o),
   .underflow_o  (underflow_o)
);

// File: tb/tfr_tx_framer_bench.sv
`timescale 1ns/1ps
module tfr_tx_framer_bench;

   localparam int TICK_DIV = 4;
   localparam int PRE_SYM  = 8;
   localparam int HDR_SYM  = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       clr_i = 1'b0;
   logic       sym_tick_i = 1'b0;
   logic [7:0] fifo_data_i;
   logic       fifo_empty_i;
   logic       fifo_rd_o;
   logic [3:0] sym_o;
   logic       sym_valid_o;
   logic       sfd_o;
   logic       underflow_o;

   tfr_tx_framer u_tfr_tx_framer (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .clr_i        (clr_i),
      .sym_tick_i   (sym_tick_i),
      .fifo_data_i  (fifo_data_i),
      .fifo_empty_i (fifo_empty_i),
      .fifo_rd_o    (fifo_rd_o),
      .sym_o        (sym_o),
      .sym_valid_o  (sym_valid_o),
      .sfd_o        (sfd_o),
      .underflow_o  (underflow_o)
   );

   always #10 clk = ~clk;

   logic [7:0] mem [256];
   logic [7:0] rd_ptr;
   logic [7:0] wr_ptr = 8'd0;
   assign fifo_data_i  = mem[rd_ptr];
   assign fifo_empty_i = (rd_ptr == wr_ptr);

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rd_ptr <= 8'd0;
      else if (fifo_rd_o) rd_ptr <= rd_ptr + 8'd1;
   end

   int         n_checks = 0;
   int         n_fails  = 0;
   bit         done     = 1'b0;
   int         div      = 0;
   int         tick_no  = 0;
   int         start_tick = 0;
   bit         req_start = 1'b0;
   bit         req_clr   = 1'b0;
   int         ncap = 0;
   int         sfd_cycles = 0;
   int         pulse_err = 0;
   bit         prev_valid = 1'b0;
   logic [3:0] cap_sym [512];
   logic       cap_sfd [512];
   int         cap_tick [512];
   logic [3:0] exp_sym [512];
   int         nexp;

   always @(negedge clk) begin
      if (sym_valid_o) begin
         if (ncap < 512) begin
            cap_sym[ncap]  = sym_o;
            cap_sfd[ncap]  = sfd_o;
            cap_tick[ncap] = tick_no;
         end
         ncap++;
         if (prev_valid) pulse_err++;
      end
      prev_valid = sym_valid_o;
      if (sfd_o) sfd_cycles++;
      div = (div == TICK_DIV - 1) ? 0 : div + 1;
      sym_tick_i = (div == 0);
      if (sym_tick_i) tick_no++;
      start_i = 1'b0;
      if (req_start && !sym_tick_i) begin
         start_i    = 1'b1;
         start_tick = tick_no;
         req_start  = 1'b0;
      end
      clr_i   = req_clr;
      req_clr = 1'b0;
   end

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r;
      logic fb;
      r = c;
      for (int i = 0; i < 8; i++) begin
         fb = r[0] ^ b[i];
         r  = {1'b0, r[15:1]};
         if (fb) r = r ^ 16'h8408;
      end
      return r;
   endfunction

   task automatic cmp_range(input int lo, input int hi, input string tag);
      int bad = -1;
      for (int i = lo; i < hi; i++)
         if (bad < 0 && (i >= ncap || cap_sym[i] !== exp_sym[i])) bad = i;
      if (bad < 0) chk(1'b1, tag, "symbols", 0, 0);
      else chk(1'b0, tag, $sformatf("symbol %0d", bad),
               (bad < ncap) ? int'(cap_sym[bad]) : -1, int'(exp_sym[bad]));
   endtask

   task automatic run_frame(input logic [7:0] lenb, input int nload, input bit extra, input bit exp_unf);
      logic [7:0]  bytes [130];
      logic [15:0] crc;
      int L, body, total, nl, st, rd0, nreads, nafter;
      bit full;
      L     = int'(lenb[6:0]);
      body  = (L < 2) ? 0 : L - 2;
      total = 1 + body;
      nl    = (nload < 0 || nload > total) ? total : nload;
      full  = (nl == total);
      bytes[0] = lenb;
      crc = 16'h0000;
      for (int i = 1; i <= body; i++) begin
         bytes[i] = 8'($urandom);
         crc = crc_step(crc, bytes[i]);
      end
      nexp = 0;
      for (int i = 0; i < PRE_SYM; i++) begin exp_sym[nexp] = 4'h0; nexp++; end
      exp_sym[nexp] = 4'h7; nexp++;
      exp_sym[nexp] = 4'hA; nexp++;
      for (int i = 0; i < nl; i++) begin
         exp_sym[nexp] = bytes[i][3:0]; nexp++;
         exp_sym[nexp] = bytes[i][7:4]; nexp++;
      end
      if (full) begin
         exp_sym[nexp] = crc[3:0];   nexp++;
         exp_sym[nexp] = crc[7:4];   nexp++;
         exp_sym[nexp] = crc[11:8];  nexp++;
         exp_sym[nexp] = crc[15:12]; nexp++;
      end
      for (int i = 0; i < nl; i++) begin mem[wr_ptr] = bytes[i]; wr_ptr = wr_ptr + 8'd1; end
      @(negedge clk);
      rd0 = int'(rd_ptr);
      ncap = 0; sfd_cycles = 0; pulse_err = 0;
      req_start = 1'b1;
      wait (!req_start);
      st = start_tick;
      if (extra) begin
         repeat (6 * TICK_DIV) @(posedge clk);
         req_start = 1'b1;
         wait (!req_start);
      end
      repeat ((16 + nexp + (extra ? 30 : 0)) * TICK_DIV + 8) @(posedge clk);
      @(negedge clk);
      chk(ncap == nexp, extra ? "R10" : "R4", "symbol count", ncap, nexp);
      if (ncap > 0) chk(cap_tick[0] - st == 13, "R2", "ticks to first symbol", cap_tick[0] - st, 13);
      cmp_range(0, HDR_SYM, "R3");
      cmp_range(HDR_SYM, HDR_SYM + 2 * nl, "R4");
      if (full) cmp_range(HDR_SYM + 2 * nl, nexp, "R5");
      nafter = nexp - HDR_SYM;
      chk(sfd_cycles == nafter * TICK_DIV, "R6", "sfd high cycles", sfd_cycles, nafter * TICK_DIV);
      begin
         bit sfd_ok = 1'b1;
         for (int i = 0; i < ncap && i < 512; i++)
            if (cap_sfd[i] !== (i >= HDR_SYM)) sfd_ok = 1'b0;
         chk(sfd_ok && sfd_o == 1'b0, "R6", "sfd per symbol / final", int'(sfd_o), 0);
      end
      nreads = int'(8'(rd_ptr - 8'(rd0)));
      chk(nreads == nl, "R7", "fifo reads", nreads, nl);
      chk(underflow_o == exp_unf, "R8", "underflow flag", int'(underflow_o), int'(exp_unf));
      chk(pulse_err == 0, "R11", "valid pulse overlap", pulse_err, 0);
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk(!sym_valid_o && !sfd_o && !underflow_o && !fifo_rd_o, "R1", "outputs in reset",
          int'({sym_valid_o, sfd_o, underflow_o, fifo_rd_o}), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(!sym_valid_o && !sfd_o && !underflow_o && !fifo_rd_o, "R1", "outputs after reset",
          int'({sym_valid_o, sfd_o, underflow_o, fifo_rd_o}), 0);

      run_frame(8'h00, -1, 1'b0, 1'b0);   // R4: L=0, no body
      run_frame(8'h02, -1, 1'b0, 1'b0);   // R5: L=2, empty body crc
      run_frame(8'h85, -1, 1'b0, 1'b0);   // R4: bit 7 ignored
      for (int k = 0; k < 6; k++)
         run_frame(8'(2 + ($urandom % 23)), -1, 1'b0, 1'b0);
      run_frame(8'h7F, -1, 1'b0, 1'b0);   // longest frame
      run_frame(8'h08, -1, 1'b1, 1'b0);   // R10 start during frame

      run_frame(8'h0A, 3, 1'b0, 1'b1);    // R8 underflow mid body
      run_frame(8'h06, -1, 1'b0, 1'b1);   // R9 still sticky
      req_clr = 1'b1;
      repeat (3) @(negedge clk);
      chk(underflow_o == 1'b0, "R9", "flag after clear", int'(underflow_o), 0);
      run_frame(8'h09, 0, 1'b0, 1'b1);    // R8 underflow at length byte
      req_clr = 1'b1;
      repeat (3) @(negedge clk);
      chk(underflow_o == 1'b0, "R9", "flag after second clear", int'(underflow_o), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule